// File: doc/BRIEF.md
# Address-Space-Tagged Translation Buffer with Access Rights

This block is a small, fully associative translation cache. It turns a virtual address into a physical address in one combinational lookup. Each slot holds a valid flag, a virtual page number, a physical frame number, three access-right bits and an 8-bit address-space tag. A lookup finds an entry only when the page number and the tag both match a valid slot. A matching entry can still refuse the access: the requested kind of access (read, write or execute) is checked against the entry's rights.

The block does not walk page tables. When no slot matches, it raises `miss`. An external walker or a software handler then supplies the translation through the fill port. A fill goes to the slot that already holds the same page and tag if there is one, otherwise to the lowest-numbered empty slot, and otherwise to a round-robin victim. Software can drop every entry at once, or only the entries of one address space.

Top module: `tlb_xlate`

## Requirements
- R1: After reset every slot is empty, so every lookup reports `miss`=1 and `hit`=0.
- R2: A lookup hits only when a valid slot's page number equals `lk_vaddr[15:8]` and its tag equals `lk_asid`. On a permitted hit, `pa` is the slot's frame number in bits 15:8 with `lk_vaddr[7:0]` copied unchanged into bits 7:0.
- R3: A slot whose page matches but whose tag differs from `lk_asid` gives `miss`=1 and `hit`=0.
- R4: The access-right bits are bit0 = read, bit1 = write and bit2 = execute. The access codes on `lk_acc` are 0 = read, 1 = write and 2 = execute; code 3 is never allowed. On a hit whose right bit is clear, `prot_fault`=1, `hit`=1 and `pa`=0.
- R5: With `lk_req`=0, `hit`, `miss` and `prot_fault` are all 0. `hit` and `miss` are never 1 together.
- R6: A fill with no matching slot goes to the lowest-numbered empty slot. When every slot is valid, it replaces a round-robin victim. The victim starts at slot 0 after reset or a full flush and advances by one for each such replacement, so the oldest of the slots filled in order is evicted first.
- R7: A fill whose page and tag already sit in a valid slot overwrites that slot. It never creates a second valid copy and never uses up a free slot.
- R8: `flush_all` empties every slot at the next clock edge.
- R9: `flush_tag_en` empties at the next edge only the slots whose tag equals `flush_tag`. All other slots keep hitting.
- R10: Lookup is combinational. A fill becomes visible only after the next rising clock edge, and a cycle with no fill and no flush leaves the set of valid slots unchanged.
- R11: A fill presented in the same cycle as either flush is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_req | input | 1 | Lookup request |
| lk_vaddr | input | 16 | Virtual address to translate |
| lk_acc | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| lk_asid | input | 8 | Address-space tag of the running context |
| fill_en | input | 1 | Write a translation |
| fill_vpn | input | 8 | Page number to install |
| fill_pfn | input | 8 | Frame number to install |
| fill_prot | input | 3 | Rights to install {exec, write, read} |
| fill_asid | input | 8 | Tag to install |
| flush_all | input | 1 | Empty every slot |
| flush_tag_en | input | 1 | Empty the slots of one tag |
| flush_tag | input | 8 | Tag for the selective flush |
| pa | output | 16 | Physical address on a permitted hit, else 0 |
| hit | output | 1 | A valid slot matches page and tag |
| miss | output | 1 | Lookup request with no matching slot |
| prot_fault | output | 1 | Hit whose rights refuse the access |

## Verification
The hardest state to reach from the ports is a full buffer whose round-robin victim sits at a known slot. It needs every slot valid, with no stale entries or pointer position carried over from earlier scenarios. The bench first issues a full flush, which also rewinds the victim pointer. It then fills exactly as many distinct pages as there are slots, and adds extra pages one at a time, checking after each one which earlier page disappeared. A second scenario leaves one slot free and re-fills a page that is already present, then proves the free slot was kept by filling it and finding every page still resident.

// File: rtl/tlb_pkg.sv
// Shared definitions for the translation buffer: access-kind codes and the
// rights check. Assumes rights are {exec, write, read} from MSB to LSB.
package tlb_pkg;
    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_NONE  = 2'd3
    } acc_e;

    localparam int RIGHTS_W = 3;

    // Returns 1 when the rights allow the requested kind of access.
    function automatic logic access_ok(input logic [1:0] acc, input logic [RIGHTS_W-1:0] rights);
        case (acc)
            2'd0:    access_ok = rights[0];
            2'd1:    access_ok = rights[1];
            2'd2:    access_ok = rights[2];
            default: access_ok = 1'b0;
        endcase
    endfunction
endpackage

// File: rtl/tlb_match_array.sv
// Compares a page/tag key against every slot in parallel. Produces the match
// vector, an any-match flag and the lowest matching index. Assumes the slots
// hold no duplicates, so at most one bit is set in normal operation.
module tlb_match_array #(
    parameter int N      = 8,
    parameter int VPN_W  = 8,
    parameter int ASID_W = 8,
    parameter int IDX_W  = $clog2(N)
) (
    input  logic [N-1:0]             valid,
    input  logic [N-1:0][VPN_W-1:0]  vpn_tab,
    input  logic [N-1:0][ASID_W-1:0] asid_tab,
    input  logic [VPN_W-1:0]         key_vpn,
    input  logic [ASID_W-1:0]        key_asid,
    output logic [N-1:0]             match,
    output logic                     any,
    output logic [IDX_W-1:0]         idx
);
    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_cmp
            // One comparator per slot: valid, page and tag must all agree.
            assign match[g] = valid[g] && (vpn_tab[g] == key_vpn) && (asid_tab[g] == key_asid);
        end
    endgenerate

    // Encode the lowest matching slot.
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (match[i]) idx = IDX_W'(i);
        end
    end

    assign any = |match;
endmodule

// File: rtl/tlb_victim_sel.sv
// Chooses the slot a fill writes. The slot already holding the same page and
// tag comes first, then the lowest empty slot, then a round-robin pointer.
// The pointer advances only when a fill replaces a valid slot.
module tlb_victim_sel #(
    parameter int N     = 8,
    parameter int IDX_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     valid,
    input  logic             dup_any,
    input  logic [IDX_W-1:0] dup_idx,
    input  logic             commit,
    input  logic             rewind,
    output logic [IDX_W-1:0] idx
);
    logic             free_any;
    logic [IDX_W-1:0] free_idx;
    logic [IDX_W-1:0] rr_q;

    // Find the lowest-numbered empty slot.
    always_comb begin
        free_any = 1'b0;
        free_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!valid[i]) begin
                free_any = 1'b1;
                free_idx = IDX_W'(i);
            end
        end
    end

    // Apply the placement priority.
    always_comb begin
        if (dup_any)       idx = dup_idx;
        else if (free_any) idx = free_idx;
        else               idx = rr_q;
    end

    // Move the round-robin pointer on replacements and rewind it on a full flush.
    always_ff @(posedge clk) begin
        if (!rst_n)      rr_q <= '0;
        else if (rewind) rr_q <= '0;
        else if (commit && !dup_any && !free_any)
            rr_q <= (rr_q == IDX_W'(N - 1)) ? '0 : rr_q + 1'b1;
    end
endmodule

// File: rtl/tlb_entry_store.sv
// Register array of translation slots. A full flush beats a tag flush, and a
// tag flush beats a write. Assumes the caller already suppresses writes
// during flush cycles.
module tlb_entry_store #(
    parameter int N      = 8,
    parameter int VPN_W  = 8,
    parameter int PFN_W  = 8,
    parameter int ASID_W = 8,
    parameter int RW     = 3,
    parameter int IDX_W  = $clog2(N)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [IDX_W-1:0]         wr_idx,
    input  logic [VPN_W-1:0]         wr_vpn,
    input  logic [PFN_W-1:0]         wr_pfn,
    input  logic [RW-1:0]            wr_rights,
    input  logic [ASID_W-1:0]        wr_asid,
    input  logic                     flush_all,
    input  logic                     flush_tag_en,
    input  logic [ASID_W-1:0]        flush_tag,
    output logic [N-1:0]             valid_q,
    output logic [N-1:0][VPN_W-1:0]  vpn_q,
    output logic [N-1:0][PFN_W-1:0]  pfn_q,
    output logic [N-1:0][RW-1:0]     rights_q,
    output logic [N-1:0][ASID_W-1:0] asid_q
);
    // Update the valid flags and slot fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q  <= '0;
            vpn_q    <= '0;
            pfn_q    <= '0;
            rights_q <= '0;
            asid_q   <= '0;
        end else if (flush_all) begin
            valid_q <= '0;
        end else if (flush_tag_en) begin
            for (int i = 0; i < N; i++) begin
                if (asid_q[i] == flush_tag) valid_q[i] <= 1'b0;
            end
        end else if (wr_en) begin
            valid_q[wr_idx]  <= 1'b1;
            vpn_q[wr_idx]    <= wr_vpn;
            pfn_q[wr_idx]    <= wr_pfn;
            rights_q[wr_idx] <= wr_rights;
            asid_q[wr_idx]   <= wr_asid;
        end
    end
endmodule

// File: rtl/tlb_xlate.sv
// Top of the tagged translation buffer. The lookup path is combinational from
// address, tag and access kind. Fills and flushes act at the next rising edge.
// Assumes a power-of-two slot count of at least two.
module tlb_xlate #(
    parameter int VA_W    = 16,
    parameter int OFS_W   = 8,
    parameter int PA_W    = 16,
    parameter int ASID_W  = 8,
    parameter int ENTRIES = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    lk_req,
    input  logic [VA_W-1:0]         lk_vaddr,
    input  logic [1:0]              lk_acc,
    input  logic [ASID_W-1:0]       lk_asid,
    input  logic                    fill_en,
    input  logic [VA_W-OFS_W-1:0]   fill_vpn,
    input  logic [PA_W-OFS_W-1:0]   fill_pfn,
    input  logic [2:0]              fill_prot,
    input  logic [ASID_W-1:0]       fill_asid,
    input  logic                    flush_all,
    input  logic                    flush_tag_en,
    input  logic [ASID_W-1:0]       flush_tag,
    output logic [PA_W-1:0]         pa,
    output logic                    hit,
    output logic                    miss,
    output logic                    prot_fault
);
    import tlb_pkg::*;

    localparam int VPN_W = VA_W - OFS_W;
    localparam int PFN_W = PA_W - OFS_W;
    localparam int IDX_W = $clog2(ENTRIES);

    logic [ENTRIES-1:0]             valid_q;
    logic [ENTRIES-1:0][VPN_W-1:0]  vpn_q;
    logic [ENTRIES-1:0][PFN_W-1:0]  pfn_q;
    logic [ENTRIES-1:0][RIGHTS_W-1:0] rights_q;
    logic [ENTRIES-1:0][ASID_W-1:0] asid_q;

    logic [ENTRIES-1:0] lk_match, dup_match;
    logic               lk_any, dup_any, commit, allowed;
    logic [IDX_W-1:0]   lk_idx, dup_idx, wr_idx;

    // A fill is dropped in any cycle that carries a flush.
    assign commit = fill_en && !flush_all && !flush_tag_en;

    tlb_match_array #(.N(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_lk_match (
        .valid(valid_q), .vpn_tab(vpn_q), .asid_tab(asid_q),
        .key_vpn(lk_vaddr[VA_W-1:OFS_W]), .key_asid(lk_asid),
        .match(lk_match), .any(lk_any), .idx(lk_idx)
    );

    tlb_match_array #(.N(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_dup_match (
        .valid(valid_q), .vpn_tab(vpn_q), .asid_tab(asid_q),
        .key_vpn(fill_vpn), .key_asid(fill_asid),
        .match(dup_match), .any(dup_any), .idx(dup_idx)
    );

    tlb_victim_sel #(.N(ENTRIES)) u_victim (
        .clk(clk), .rst_n(rst_n), .valid(valid_q),
        .dup_any(dup_any), .dup_idx(dup_idx),
        .commit(commit), .rewind(flush_all), .idx(wr_idx)
    );

    tlb_entry_store #(.N(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W), .ASID_W(ASID_W),
                      .RW(RIGHTS_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .wr_en(commit), .wr_idx(wr_idx), .wr_vpn(fill_vpn), .wr_pfn(fill_pfn),
        .wr_rights(fill_prot), .wr_asid(fill_asid),
        .flush_all(flush_all), .flush_tag_en(flush_tag_en), .flush_tag(flush_tag),
        .valid_q(valid_q), .vpn_q(vpn_q), .pfn_q(pfn_q), .rights_q(rights_q), .asid_q(asid_q)
    );

    // Resolve the lookup: flags, rights check and the physical address.
    always_comb begin
        allowed    = access_ok(lk_acc, rights_q[lk_idx]);
        hit        = lk_req && lk_any;
        miss       = lk_req && !lk_any;
        prot_fault = hit && !allowed;
        pa         = (hit && allowed) ? {pfn_q[lk_idx], lk_vaddr[OFS_W-1:0]} : '0;
    end
endmodule

// File: rtl/tlb_xlate_chk.sv
// Property checker for the translation buffer, attached by bind. Watches the
// lookup flags, the match vector and the valid flags over time.
module tlb_xlate_chk #(
    parameter int N     = 8,
    parameter int VA_W  = 16,
    parameter int OFS_W = 8,
    parameter int PA_W  = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            lk_req,
    input logic [VA_W-1:0] lk_vaddr,
    input logic [PA_W-1:0] pa,
    input logic            hit,
    input logic            miss,
    input logic            prot_fault,
    input logic            fill_en,
    input logic            flush_all,
    input logic            flush_tag_en,
    input logic [N-1:0]    valid_q,
    input logic [N-1:0]    lk_match
);
    p_single_copy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_match));

    p_idle_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_req |-> (!hit && !miss && !prot_fault));

    p_hit_miss_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(hit && miss));

    p_fault_needs_hit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        prot_fault |-> hit);

    p_offset_kept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !prot_fault) |-> (pa[OFS_W-1:0] == lk_vaddr[OFS_W-1:0]));

    p_flush_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flush_all |=> (valid_q == '0));

    p_quiet_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!fill_en && !flush_all && !flush_tag_en) |=> $stable(valid_q));
endmodule

bind tlb_xlate tlb_xlate_chk #(.N(ENTRIES), .VA_W(VA_W), .OFS_W(OFS_W), .PA_W(PA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_vaddr(lk_vaddr), .pa(pa),
    .hit(hit), .miss(miss), .prot_fault(prot_fault), .fill_en(fill_en),
    .flush_all(flush_all), .flush_tag_en(flush_tag_en),
    .valid_q(valid_q), .lk_match(lk_match)
);

// File: tb/tlb_xlate_bench.sv
// Directed bench: one task per scenario, each checking its own results.
module tlb_xlate_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_req = 1'b0;
    logic [15:0] lk_vaddr = '0;
    logic [1:0]  lk_acc = '0;
    logic [7:0]  lk_asid = '0;
    logic        fill_en = 1'b0;
    logic [7:0]  fill_vpn = '0, fill_pfn = '0, fill_asid = '0;
    logic [2:0]  fill_prot = '0;
    logic        flush_all = 1'b0, flush_tag_en = 1'b0;
    logic [7:0]  flush_tag = '0;
    logic [15:0] pa;
    logic        hit, miss, prot_fault;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    tlb_xlate u_tlb_xlate (
        .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_vaddr(lk_vaddr), .lk_acc(lk_acc),
        .lk_asid(lk_asid), .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_pfn(fill_pfn),
        .fill_prot(fill_prot), .fill_asid(fill_asid), .flush_all(flush_all),
        .flush_tag_en(flush_tag_en), .flush_tag(flush_tag),
        .pa(pa), .hit(hit), .miss(miss), .prot_fault(prot_fault)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic expect_out(input string tag, input logic eh, input logic em,
                              input logic ef, input logic [15:0] epa);
        n_vec++;
        if (hit !== eh || miss !== em || prot_fault !== ef || pa !== epa) begin
            n_bad++;
            $display("FAIL %s: got hit=%0b miss=%0b fault=%0b pa=%h, expected hit=%0b miss=%0b fault=%0b pa=%h",
                     tag, hit, miss, prot_fault, pa, eh, em, ef, epa);
        end
    endtask

    task automatic look(input logic [15:0] va, input logic [1:0] acc, input logic [7:0] asid);
        @(negedge clk);
        lk_req = 1'b1; lk_vaddr = va; lk_acc = acc; lk_asid = asid;
        #1;
    endtask

    task automatic do_fill(input logic [7:0] vpn, input logic [7:0] pfn,
                           input logic [2:0] prot, input logic [7:0] asid);
        @(negedge clk);
        fill_en = 1'b1; fill_vpn = vpn; fill_pfn = pfn; fill_prot = prot; fill_asid = asid;
        @(negedge clk);
        fill_en = 1'b0;
    endtask

    task automatic do_flush_all();
        @(negedge clk); flush_all = 1'b1;
        @(negedge clk); flush_all = 1'b0;
    endtask

    task automatic t_reset_state();
        look(16'h1234, 2'd0, 8'd0);   expect_out("R1 empty after reset", 0, 1, 0, 16'h0);
        look(16'h0000, 2'd2, 8'd255); expect_out("R1 empty after reset", 0, 1, 0, 16'h0);
    endtask

    task automatic t_basic_hit();
        do_fill(8'hAA, 8'h91, 3'b111, 8'd211);
        look(16'hAA10, 2'd0, 8'd211); expect_out("R2 read hit", 1, 0, 0, 16'h9110);
        look(16'hAAFF, 2'd2, 8'd211); expect_out("R2 offset kept", 1, 0, 0, 16'h91FF);
        look(16'hAB10, 2'd0, 8'd211); expect_out("R2 other page misses", 0, 1, 0, 16'h0);
    endtask

    task automatic t_asid_mismatch();
        look(16'hAA10, 2'd0, 8'd112); expect_out("R3 foreign tag misses", 0, 1, 0, 16'h0);
        do_fill(8'hAA, 8'h23, 3'b111, 8'd112);
        look(16'hAA10, 2'd0, 8'd112); expect_out("R3 own tag frame", 1, 0, 0, 16'h2310);
        look(16'hAA10, 2'd0, 8'd211); expect_out("R3 first tag intact", 1, 0, 0, 16'h9110);
    endtask

    task automatic t_protection();
        do_fill(8'h50, 8'h60, 3'b001, 8'd2);
        look(16'h5004, 2'd0, 8'd2); expect_out("R4 read allowed", 1, 0, 0, 16'h6004);
        look(16'h5004, 2'd1, 8'd2); expect_out("R4 write refused", 1, 0, 1, 16'h0);
        look(16'h5004, 2'd2, 8'd2); expect_out("R4 exec refused", 1, 0, 1, 16'h0);
        do_fill(8'h51, 8'h61, 3'b110, 8'd2);
        look(16'h5108, 2'd0, 8'd2); expect_out("R4 read refused", 1, 0, 1, 16'h0);
        look(16'h5108, 2'd1, 8'd2); expect_out("R4 write allowed", 1, 0, 0, 16'h6108);
        look(16'h5108, 2'd2, 8'd2); expect_out("R4 exec allowed", 1, 0, 0, 16'h6108);
        look(16'h5108, 2'd3, 8'd2); expect_out("R4 code 3 refused", 1, 0, 1, 16'h0);
    endtask

    task automatic t_idle_flags();
        @(negedge clk);
        lk_req = 1'b0; lk_vaddr = 16'h5004; lk_acc = 2'd1; lk_asid = 8'd2;
        #1; expect_out("R5 idle on fault case", 0, 0, 0, 16'h0);
        lk_vaddr = 16'h7777; #1; expect_out("R5 idle on miss case", 0, 0, 0, 16'h0);
    endtask

    task automatic t_fill_timing();
        look(16'h7001, 2'd0, 8'd9);
        @(negedge clk);
        fill_en = 1'b1; fill_vpn = 8'h70; fill_pfn = 8'hC3; fill_prot = 3'b001; fill_asid = 8'd9;
        #1; expect_out("R10 not visible before edge", 0, 1, 0, 16'h0);
        @(posedge clk); #1;
        fill_en = 1'b0;
        expect_out("R10 visible after edge", 1, 0, 0, 16'hC301);
    endtask

    task automatic t_round_robin();
        do_flush_all();
        for (int i = 0; i < 8; i++) do_fill(8'h10 + 8'(i), 8'h80 + 8'(i), 3'b001, 8'd1);
        for (int i = 0; i < 8; i++) begin
            look({8'h10 + 8'(i), 8'h00}, 2'd0, 8'd1);
            expect_out("R6 all slots filled", 1, 0, 0, {8'h80 + 8'(i), 8'h00});
        end
        do_fill(8'h20, 8'hA0, 3'b001, 8'd1);
        look(16'h1000, 2'd0, 8'd1); expect_out("R6 oldest evicted", 0, 1, 0, 16'h0);
        look(16'h1100, 2'd0, 8'd1); expect_out("R6 second kept", 1, 0, 0, 16'h8100);
        look(16'h2000, 2'd0, 8'd1); expect_out("R6 new page in", 1, 0, 0, 16'hA000);
        do_fill(8'h21, 8'hA1, 3'b001, 8'd1);
        look(16'h1100, 2'd0, 8'd1); expect_out("R6 pointer advanced", 0, 1, 0, 16'h0);
        look(16'h1200, 2'd0, 8'd1); expect_out("R6 third kept", 1, 0, 0, 16'h8200);
    endtask

    task automatic t_refill_in_place();
        do_flush_all();
        for (int i = 0; i < 7; i++) do_fill(8'h30 + 8'(i), 8'h40 + 8'(i), 3'b001, 8'd3);
        do_fill(8'h33, 8'hEE, 3'b001, 8'd3);
        do_fill(8'h37, 8'h47, 3'b001, 8'd3);
        look(16'h3300, 2'd0, 8'd3); expect_out("R7 refill updates frame", 1, 0, 0, 16'hEE00);
        for (int i = 0; i < 8; i++) begin
            if (i != 3) begin
                look({8'h30 + 8'(i), 8'h05}, 2'd0, 8'd3);
                expect_out("R7 free slot kept", 1, 0, 0, {8'h40 + 8'(i), 8'h05});
            end
        end
    endtask

    task automatic t_flush_all();
        do_fill(8'h90, 8'h11, 3'b001, 8'd4);
        do_flush_all();
        look(16'h9000, 2'd0, 8'd4); expect_out("R8 flushed page", 0, 1, 0, 16'h0);
        look(16'h3000, 2'd0, 8'd3); expect_out("R8 flushed page", 0, 1, 0, 16'h0);
    endtask

    task automatic t_flush_tag();
        do_fill(8'h40, 8'h14, 3'b001, 8'd5);
        do_fill(8'h41, 8'h15, 3'b001, 8'd6);
        do_fill(8'h40, 8'h16, 3'b001, 8'd6);
        @(negedge clk); flush_tag_en = 1'b1; flush_tag = 8'd5;
        @(negedge clk); flush_tag_en = 1'b0;
        look(16'h4022, 2'd0, 8'd5); expect_out("R9 tagged slot gone", 0, 1, 0, 16'h0);
        look(16'h4122, 2'd0, 8'd6); expect_out("R9 other tag kept", 1, 0, 0, 16'h1522);
        look(16'h4022, 2'd0, 8'd6); expect_out("R9 same page other tag", 1, 0, 0, 16'h1622);
    endtask

    task automatic t_flush_priority();
        @(negedge clk);
        flush_all = 1'b1; fill_en = 1'b1; fill_vpn = 8'hB0; fill_pfn = 8'h33; fill_prot = 3'b001; fill_asid = 8'd7;
        @(negedge clk); flush_all = 1'b0; fill_en = 1'b0;
        look(16'hB000, 2'd0, 8'd7); expect_out("R11 fill dropped under full flush", 0, 1, 0, 16'h0);
        @(negedge clk);
        flush_tag_en = 1'b1; flush_tag = 8'd99; fill_en = 1'b1; fill_vpn = 8'hB1; fill_asid = 8'd7;
        @(negedge clk); flush_tag_en = 1'b0; fill_en = 1'b0;
        look(16'hB100, 2'd0, 8'd7); expect_out("R11 fill dropped under tag flush", 0, 1, 0, 16'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_basic_hit();
        t_asid_mismatch();
        t_protection();
        t_idle_flags();
        t_fill_timing();
        t_round_robin();
        t_refill_in_place();
        t_flush_all();
        t_flush_tag();
        t_flush_priority();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule